// File: doc/BRIEF.md
# Segmented Prediction Adder

This block is a purely combinational, approximate adder for two unsigned operands. The carry chain is cut into a fixed number of lanes that all evaluate in parallel. Each lane owns a group of result bits. It also looks at a few operand bits just below its group, the guard bits, and adds them with the group so that the carry entering the group is estimated locally. No carry ever travels from one lane to the next. The longest path is therefore one lane wide and not the full operand width.

The lane layout is fixed at elaboration by two parameter lists. One gives the result width of each lane and the other gives its guard width. The operand width is the larger of the two input widths, and the narrower input is zero-extended to it. A layout that breaks the lane rules stops elaboration with an error message. The rules are: every lane has a result width of at least one, the result widths sum to the operand width, lane 0 has no guard bits, each guard window starts above the start of the previous lane's window, and list entries past the last lane are zero. The sum is one bit wider than the operands.

Top module: `quad_seg_adder`

## Requirements
- R1: Lane g adds an unsigned window of both extended operands that is RES_W[g]+PRED_W[g] bits wide. The window's top bit is (RES_W[0]+...+RES_W[g])-1, and the lane produces a carry-out above the window.
- R2: The result bits of lane g are window-sum bits PRED_W[g] upward. They land in sum_o starting at bit RES_W[0]+...+RES_W[g-1], so lanes fill the output from bit 0 in lane order. Zero operands give a zero sum.
- R3: Bit OP_W of sum_o is the carry-out of the last lane.
- R4: The narrower operand is zero-extended to OP_W = max(A_W, B_W) before any lane takes its window.
- R5: A carry produced below a lane's window is lost, so the sum can fall short of the exact sum. Example with the default layout, where the lanes take operand bits [3:0], [7:2], [11:5] and [15:10]: 0x0001 + 0x0FF yields 0x00F0, and 0xFE00 + 0x200 yields 0x0F000.
- R6: When the second operand is zero, sum_o equals the zero-extended first operand.
- R7: When no carry enters a lane's window from the bits below it, that lane's result bits and its carry-out equal the matching bits of the exact sum.
- R8: A layout with a single lane and no guard bits gives the exact sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | A_W | First unsigned operand |
| opb_i | input | B_W | Second unsigned operand |
| sum_o | output | OP_W+1 | Approximate sum; top bit is the carry-out of the last lane |

## Verification
Two effects can occur on the same input vector. One lane can lose a carry generated below its window while the next lane up still predicts its own carry correctly. In the same way, the last lane's carry-out can be correct or lost together with a lower lane's error. Directed vectors such as 0xFE00 + 0x200 and all-ones operands provoke both at once. Each vector is judged against a bench model built from the per-lane window equations, a literal value derived by hand, and a single-lane exact instance driven in parallel.

// File: rtl/quad_pkg.sv
`timescale 1ns/1ps
package quad_pkg;

    // Capacity of the lane lists carried as parameters.
    localparam int unsigned MAX_SEG = 16;

    typedef int unsigned width_list_t [MAX_SEG];

    // Output of one full-sum lane cell.
    typedef struct packed {
        logic sum;
        logic carry;
    } cell_out_t;

    function automatic int unsigned umax(input int unsigned x, input int unsigned y);
        return (x > y) ? x : y;
    endfunction

    // Sum of the first `upto` entries of a width list.
    function automatic int unsigned prefix_sum(input width_list_t w, input int unsigned upto);
        int unsigned acc;
        acc = 0;
        for (int k = 0; k < MAX_SEG; k++) begin
            if (k < upto) acc += w[k];
        end
        return acc;
    endfunction

    // Lowest operand bit seen by lane `seg`.
    function automatic int unsigned window_lo(input width_list_t res,
                                              input width_list_t pred,
                                              input int unsigned seg);
        return prefix_sum(res, seg + 1) + pred[0] - res[seg] - pred[seg];
    endfunction

endpackage

// File: rtl/quad_full_cell.sv
`timescale 1ns/1ps
module quad_full_cell
    import quad_pkg::*;
(
    input  logic      x_i,
    input  logic      y_i,
    input  logic      c_i,
    output cell_out_t res_o
);
    logic half;

    assign half        = x_i ^ y_i;
    assign res_o.sum   = half ^ c_i;
    assign res_o.carry = (x_i & y_i) | (c_i & half);
endmodule

// File: rtl/quad_carry_cell.sv
`timescale 1ns/1ps
module quad_carry_cell (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic c_o
);
    // Guard positions only feed the chain; their sum bit is never used.
    assign c_o = (x_i & y_i) | (x_i & c_i) | (y_i & c_i);
endmodule

// File: rtl/quad_sub_adder.sv
`timescale 1ns/1ps
module quad_sub_adder
    import quad_pkg::*;
#(
    parameter  int unsigned RES_W  = 4,
    parameter  int unsigned PRED_W = 0,
    localparam int unsigned LANE_W = RES_W + PRED_W
) (
    input  logic [LANE_W-1:0] x_i,
    input  logic [LANE_W-1:0] y_i,
    output logic [RES_W-1:0]  kept_o,
    output logic              carry_o
);
    logic [LANE_W:0] chain;

    assign chain[0] = 1'b0;

    for (genvar i = 0; i < LANE_W; i++) begin : g_bit
        if (i < PRED_W) begin : g_guard
            quad_carry_cell u_guard (
                .x_i (x_i[i]),
                .y_i (y_i[i]),
                .c_i (chain[i]),
                .c_o (chain[i+1])
            );
        end else begin : g_keep
            cell_out_t res;
            quad_full_cell u_keep (
                .x_i   (x_i[i]),
                .y_i   (y_i[i]),
                .c_i   (chain[i]),
                .res_o (res)
            );
            assign kept_o[i-PRED_W] = res.sum;
            assign chain[i+1]       = res.carry;
        end
    end

    assign carry_o = chain[LANE_W];

    // R1: the ripple lane must agree with a behavioural window sum.
    always_comb begin
        assert_lane_sum_R1: assert ({carry_o, kept_o} ==
            (RES_W+1)'(({1'b0, x_i} + {1'b0, y_i}) >> PRED_W))
            else $error("lane sum mismatch");
    end
endmodule

// File: rtl/quad_cfg_check.sv
`timescale 1ns/1ps
module quad_cfg_check
    import quad_pkg::*;
#(
    parameter int unsigned OP_W    = 16,
    parameter int unsigned NUM_SEG = 4,
    parameter width_list_t RES_W   = '{0:4, 1:4, 2:4, 3:4, default:0},
    parameter width_list_t PRED_W  = '{0:0, 1:2, 2:3, 3:2, default:0}
) ();
    if (NUM_SEG < 1 || NUM_SEG > MAX_SEG) begin : g_bad_count
        $error("lane count out of range");
    end
    if (prefix_sum(RES_W, MAX_SEG) != OP_W) begin : g_bad_total
        $error("result widths do not cover the operand width");
    end
    if (PRED_W[0] != 0) begin : g_bad_first
        $error("lane 0 must have no guard bits");
    end
    for (genvar k = 0; k < MAX_SEG; k++) begin : g_entry
        if (k >= NUM_SEG && (RES_W[k] != 0 || PRED_W[k] != 0)) begin : g_extra
            $error("width list longer than lane count");
        end
        if (k < NUM_SEG && RES_W[k] == 0) begin : g_empty
            $error("lane with no result bits");
        end
        if (k > 0 && k < NUM_SEG && PRED_W[k] >= PRED_W[k-1] + RES_W[k-1]) begin : g_deep
            $error("guard window reaches below the previous window");
        end
    end
endmodule

// File: rtl/quad_seg_adder.sv
`timescale 1ns/1ps
module quad_seg_adder
    import quad_pkg::*;
#(
    parameter  int unsigned A_W     = 16,
    parameter  int unsigned B_W     = 16,
    parameter  int unsigned NUM_SEG = 4,
    parameter  width_list_t RES_W   = '{0:4, 1:4, 2:4, 3:4, default:0},
    parameter  width_list_t PRED_W  = '{0:0, 1:2, 2:3, 3:2, default:0},
    localparam int unsigned OP_W    = umax(A_W, B_W)
) (
    input  logic [A_W-1:0]  opa_i,
    input  logic [B_W-1:0]  opb_i,
    output logic [OP_W:0]   sum_o
);
    logic [OP_W-1:0] a_ext;
    logic [OP_W-1:0] b_ext;
    logic [OP_W:0]   exact;

    assign a_ext = OP_W'(opa_i);
    assign b_ext = OP_W'(opb_i);

    // Reference full-width sum, used only by the checks below.
    assign exact = {1'b0, a_ext} + {1'b0, b_ext};

    quad_cfg_check #(
        .OP_W    (OP_W),
        .NUM_SEG (NUM_SEG),
        .RES_W   (RES_W),
        .PRED_W  (PRED_W)
    ) u_cfg ();

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        localparam int unsigned RW = RES_W[g];
        localparam int unsigned PW = PRED_W[g];
        localparam int unsigned LW = RW + PW;
        localparam int unsigned WL = window_lo(RES_W, PRED_W, g);
        localparam int unsigned OL = prefix_sum(RES_W, g);

        logic [RW-1:0] kept;
        logic          cout;
        logic          cin_true;

        quad_sub_adder #(
            .RES_W  (RW),
            .PRED_W (PW)
        ) u_lane (
            .x_i     (a_ext[WL +: LW]),
            .y_i     (b_ext[WL +: LW]),
            .kept_o  (kept),
            .carry_o (cout)
        );

        assign sum_o[OL +: RW] = kept;

        // Carry that the exact sum feeds into the lane's lowest window bit.
        assign cin_true = exact[WL] ^ a_ext[WL] ^ b_ext[WL];

        if (g == NUM_SEG - 1) begin : g_last
            assign sum_o[OP_W] = cout;
            always_comb begin
                if (!cin_true) begin
                    assert_msb_R3: assert ({cout, kept} == exact[OL +: RW+1])
                        else $error("top lane disagrees with exact sum");
                end
            end
        end else begin : g_mid
            always_comb begin
                if (!cin_true) begin
                    assert_seg_exact_R7: assert ({cout, kept} ==
                        {exact[OL+RW] ^ a_ext[OL+RW] ^ b_ext[OL+RW], exact[OL +: RW]})
                        else $error("lane disagrees with exact sum");
                end
            end
        end
    end

    // R6: adding zero never invents a carry.
    always_comb begin
        if (b_ext == '0) begin
            assert_zero_addend_R6: assert (sum_o == {1'b0, a_ext})
                else $error("zero addend changed the operand");
        end
    end
endmodule

// File: tb/quad_seg_adder_bench.sv
`timescale 1ns/1ps
module quad_seg_adder_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [15:0] opa = '0;
    logic [11:0] opb = '0;
    logic [16:0] sum_main;
    logic [16:0] sum_single;

    quad_seg_adder #(
        .A_W     (16),
        .B_W     (12),
        .NUM_SEG (4),
        .RES_W   ('{0:4, 1:4, 2:4, 3:4, default:0}),
        .PRED_W  ('{0:0, 1:2, 2:3, 3:2, default:0})
    ) u_quad_seg_adder (
        .opa_i (opa),
        .opb_i (opb),
        .sum_o (sum_main)
    );

    quad_seg_adder #(
        .A_W     (16),
        .B_W     (16),
        .NUM_SEG (1),
        .RES_W   ('{0:16, default:0}),
        .PRED_W  ('{default:0})
    ) u_single (
        .opa_i (opa),
        .opb_i ({4'h0, opb}),
        .sum_o (sum_single)
    );

    typedef struct {
        logic [15:0] a;
        logic [11:0] b;
        logic [16:0] exp_model;
        logic [16:0] exp_exact;
        logic        has_lit;
        logic [16:0] lit;
        string       tag;
    } item_t;

    item_t sb[$];
    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    // Lane layout of the main instance, restated for the model.
    int unsigned mr [4] = '{4, 4, 4, 4};
    int unsigned mp [4] = '{0, 2, 3, 2};

    function automatic logic [16:0] model(input logic [15:0] a, input logic [11:0] b);
        int unsigned base;
        int unsigned hi, lo, w, wa, wb, s, kept;
        int unsigned ax, bx;
        logic [16:0] r;
        base = 0;
        r = '0;
        ax = 32'(a);
        bx = 32'(b);
        for (int g = 0; g < 4; g++) begin
            hi = base + mr[g] - 1;
            w  = mr[g] + mp[g];
            lo = hi + 1 - w;
            wa = (ax >> lo) & ((32'd1 << w) - 1);
            wb = (bx >> lo) & ((32'd1 << w) - 1);
            s  = wa + wb;
            kept = (s >> mp[g]) & ((32'd1 << mr[g]) - 1);
            r = r | 17'(kept << base);
            if (g == 3) r[16] = s[w];
            base += mr[g];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [16:0] got, input logic [16:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Driver: apply a vector at the falling edge and queue its expectation.
    task automatic drive(input logic [15:0] a, input logic [11:0] b, input string tag,
                         input logic has_lit, input logic [16:0] lit);
        item_t it;
        @(negedge clk);
        opa = a;
        opb = b;
        it.a = a;
        it.b = b;
        it.exp_model = model(a, b);
        it.exp_exact = {1'b0, a} + {5'b0, b};
        it.has_lit = has_lit;
        it.lit = lit;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare at the rising edge, after the inputs settled.
    always @(posedge clk) begin
        if (!rst && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check({it.tag, " vs lane model"}, sum_main, it.exp_model);
            check("R8 single lane exact", sum_single, it.exp_exact);
            if (it.has_lit) check({it.tag, " vs literal"}, sum_main, it.lit);
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        rst = 1'b0;
        drive(16'h0000, 12'h000, "R2 reset zero",           1'b1, 17'h00000);
        drive(16'h0001, 12'h0FF, "R5 carry lost lane1",     1'b1, 17'h000F0);
        drive(16'hFE00, 12'h200, "R5 carry lost top",       1'b1, 17'h0F000);
        drive(16'hABCD, 12'h000, "R6 zero addend",          1'b1, 17'h0ABCD);
        drive(16'h1234, 12'h111, "R7 no inner carries",     1'b1, 17'h01345);
        drive(16'hFFFF, 12'hFFF, "R3 all ones msb",         1'b1, 17'h10FFE);
        drive(16'hFC00, 12'h400, "R3 top carry-out",        1'b1, 17'h10000);
        drive(16'h0000, 12'hFFF, "R4 narrow operand ext",   1'b1, 17'h00FFF);
        drive(16'h0F0F, 12'h0F1, "R2 lane placement",       1'b0, 17'h0);
        for (int n = 0; n < 40; n++) begin
            drive(16'($urandom), 12'($urandom), "R1 random window", 1'b0, 17'h0);
        end
        repeat (3) @(posedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            summary();
            $finish;
        end
    end
endmodule